// File: doc/BRIEF.md
# Per-Channel Delay, Gate Stretch and Hit Counting Bank

This block prepares a bank of single-bit trigger inputs for downstream coincidence logic. It runs on a 125 MHz logic clock, so one tick is 8 ns. Each shaped channel goes through a programmable delay line. A rising edge seen at the selected tap then opens a gate whose width in ticks is programmed per channel. A further group of inputs is never shaped. Every raw input, shaped or count-only, feeds its own wrapping hit counter that counts rising edges.

The block is used with two 32-input banks concatenated into 64 shaped channels, plus 32 count-only inputs. Settings arrive as flat vectors, with one fixed-width field per channel. Counters are read one at a time through a combinational select, and one synchronous clear zeroes all of them together. Inputs must already be synchronous to the clock.

Top module: `trig_shaper_bank`

## Requirements
- R1: While reset is held and after it is released with all inputs low, every shaped output is low and every counter reads zero.
- R2: Channel i takes its delay D from `dly_cfg[i*DLY_W +: DLY_W]`, with D from 0 to 2^DLY_W-1. A rising input first sampled high at clock edge t, after a low sample at edge t-1, makes the shaped output rise after edge t+D+1, provided the gate width is nonzero. D=0 therefore leaves only the delay register stage plus the gate register.
- R3: Channel i takes its gate width W from `gate_cfg[i*GATE_W +: GATE_W]`. A delayed rising edge keeps the output high for exactly W consecutive cycles.
- R4: A delayed rising edge that arrives while the gate is open restarts the gate. The output then stays high for W cycles counted from the new edge, and it never falls in the cycle right after an edge.
- R5: A gate width of zero suppresses the output for that channel. The delayed edge produces no pulse.
- R6: Each counter increases by one for each rising edge of its raw input, meaning a low sample followed by a high sample. An input held high for many cycles counts once.
- R7: Counters are CNT_W bits wide and wrap modulo 2^CNT_W.
- R8: `cnt_clr` sampled high zeroes every counter at that edge. It takes priority over an increment in the same cycle, so a rising edge sampled with the clear is lost.
- R9: `cnt_value` shows counter `cnt_sel` combinationally. Indexes 0..N_SHAPED-1 select the shaped inputs (`raw_in` bit index), indexes N_SHAPED..N_SHAPED+N_COUNT-1 select `aux_in` bits, and any larger index reads zero.
- R10: The count-only inputs `aux_in` have no effect on any shaped output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock (125 MHz in use) |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_in | input | N_SHAPED | Synchronous trigger inputs that are shaped and counted |
| aux_in | input | N_COUNT | Synchronous inputs that are only counted |
| dly_cfg | input | N_SHAPED*DLY_W | Per-channel delay in ticks |
| gate_cfg | input | N_SHAPED*GATE_W | Per-channel gate width in ticks |
| cnt_clr | input | 1 | Synchronous clear of all counters |
| cnt_sel | input | SEL_W | Counter index for readback |
| shaped_out | output | N_SHAPED | Delayed and stretched outputs |
| cnt_value | output | CNT_W | Value of the selected counter |

## Verification
The bench builds the block with 8 shaped channels, 4 count-only inputs, 3-bit delay and gate fields and 6-bit counters. With these values the largest delay (7) and the largest gate (7) come up often under random settings, so restarts that land at the very end of a gate are frequent. A counter wraps after 64 edges, so the wrap is reached within a short directed burst and again during random traffic. The reduced select width also lets the bench walk every counter, plus out-of-range indexes, within a single low clock phase.

// File: rtl/shaper_pkg.sv
`timescale 1ns/1ps
package shaper_pkg;

  // Next gate count: a load restarts at the programmed width, otherwise count down to zero.
  function automatic int unsigned gate_next(input logic load, input int unsigned width,
                                            input int unsigned cur);
    if (load)          return width;
    else if (cur != 0) return cur - 1;
    else               return 0;
  endfunction

  // Next hit count: clear wins, otherwise add one on a rising edge (caller truncates = wrap).
  function automatic int unsigned count_next(input logic clr, input logic rise,
                                             input int unsigned cur);
    if (clr) return 0;
    return cur + (rise ? 1 : 0);
  endfunction

endpackage

// File: rtl/shaper_delay.sv
`timescale 1ns/1ps
module shaper_delay #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [DLY_W-1:0] dly,
  output logic             edge_o
);
  localparam int TAPS = (1 << DLY_W) + 1;
  localparam int IW   = DLY_W + 1;

  logic [TAPS-1:0] sr_q;
  logic [IW-1:0]   tap_now, tap_old;

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[TAPS-2:0], din};
  end

  assign tap_now = {1'b0, dly};
  assign tap_old = tap_now + IW'(1);
  // Rising edge at the selected tap: newer sample high, older sample low.
  assign edge_o  = sr_q[tap_now] & ~sr_q[tap_old];
endmodule

// File: rtl/shaper_gate.sv
`timescale 1ns/1ps
module shaper_gate #(
  parameter int GATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [GATE_W-1:0] width,
  output logic              gate_o
);
  logic [GATE_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) left_q <= '0;
    else left_q <= GATE_W'(shaper_pkg::gate_next(load, 32'(width), 32'(left_q)));
  end

  assign gate_o = (left_q != '0);
endmodule

// File: rtl/shaper_counter.sv
`timescale 1ns/1ps
module shaper_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic             clr,
  output logic             rise_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic prev_q;

  assign rise_o = din & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_o  <= '0;
    end else begin
      prev_q <= din;
      cnt_o  <= CNT_W'(shaper_pkg::count_next(clr, rise_o, 32'(cnt_o)));
    end
  end
endmodule

// File: rtl/trig_shaper_bank.sv
`timescale 1ns/1ps
module trig_shaper_bank #(
  parameter int N_SHAPED = 64,
  parameter int N_COUNT  = 32,
  parameter int DLY_W    = 4,
  parameter int GATE_W   = 4,
  parameter int CNT_W    = 24,
  localparam int N_ALL   = N_SHAPED + N_COUNT,
  localparam int SEL_W   = $clog2(N_ALL + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_SHAPED-1:0]        raw_in,
  input  logic [N_COUNT-1:0]         aux_in,
  input  logic [N_SHAPED*DLY_W-1:0]  dly_cfg,
  input  logic [N_SHAPED*GATE_W-1:0] gate_cfg,
  input  logic                       cnt_clr,
  input  logic [SEL_W-1:0]           cnt_sel,
  output logic [N_SHAPED-1:0]        shaped_out,
  output logic [CNT_W-1:0]           cnt_value
);
  // Named internal events, observed by the bound checker.
  logic [N_SHAPED-1:0]    dly_edge;
  logic [N_ALL-1:0]       raw_rise;
  logic [N_ALL*CNT_W-1:0] cnt_flat;
  logic [N_ALL-1:0]       all_in;

  assign all_in = {aux_in, raw_in};

  for (genvar i = 0; i < N_SHAPED; i++) begin : g_shape
    shaper_delay #(.DLY_W(DLY_W)) u_dly (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (raw_in[i]),
      .dly    (dly_cfg[i*DLY_W +: DLY_W]),
      .edge_o (dly_edge[i])
    );
    shaper_gate #(.GATE_W(GATE_W)) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (dly_edge[i]),
      .width  (gate_cfg[i*GATE_W +: GATE_W]),
      .gate_o (shaped_out[i])
    );
  end

  for (genvar j = 0; j < N_ALL; j++) begin : g_count
    shaper_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (all_in[j]),
      .clr    (cnt_clr),
      .rise_o (raw_rise[j]),
      .cnt_o  (cnt_flat[j*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    cnt_value = '0;
    for (int k = 0; k < N_ALL; k++)
      if (32'(cnt_sel) == k) cnt_value = cnt_flat[k*CNT_W +: CNT_W];
  end
endmodule

// File: rtl/shaper_chk.sv
`timescale 1ns/1ps
module shaper_chk #(
  parameter int N_SHAPED = 64,
  parameter int N_COUNT  = 32,
  parameter int GATE_W   = 4,
  parameter int CNT_W    = 24,
  localparam int N_ALL   = N_SHAPED + N_COUNT
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cnt_clr,
  input logic [CNT_W-1:0]           cnt_value,
  input logic [N_SHAPED-1:0]        shaped_out,
  input logic [N_SHAPED-1:0]        dly_edge,
  input logic [N_SHAPED*GATE_W-1:0] gate_cfg,
  input logic [N_ALL-1:0]           raw_rise,
  input logic [N_ALL*CNT_W-1:0]     cnt_flat
);
  for (genvar i = 0; i < N_SHAPED; i++) begin : g_sh
    assert_gate_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_edge[i] && gate_cfg[i*GATE_W +: GATE_W] != '0) |=> shaped_out[i]);
    assert_no_early_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shaped_out[i]) |-> !$past(dly_edge[i]));
    assert_zero_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_edge[i] && gate_cfg[i*GATE_W +: GATE_W] == '0) |=> !shaped_out[i]);
  end

  for (genvar j = 0; j < N_ALL; j++) begin : g_ct
    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_rise[j] && !cnt_clr) |=>
        cnt_flat[j*CNT_W +: CNT_W] == CNT_W'($past(cnt_flat[j*CNT_W +: CNT_W]) + 1'b1));
    assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!raw_rise[j] && !cnt_clr) |=> $stable(cnt_flat[j*CNT_W +: CNT_W]));
  end

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> cnt_value == '0);
endmodule

bind trig_shaper_bank shaper_chk #(
  .N_SHAPED (N_SHAPED),
  .N_COUNT  (N_COUNT),
  .GATE_W   (GATE_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_clr    (cnt_clr),
  .cnt_value  (cnt_value),
  .shaped_out (shaped_out),
  .dly_edge   (dly_edge),
  .gate_cfg   (gate_cfg),
  .raw_rise   (raw_rise),
  .cnt_flat   (cnt_flat)
);

// File: tb/trig_shaper_bank_tb.sv
`timescale 1ns/1ps
module trig_shaper_bank_tb;
  localparam int NS = 8, NA = 4, DW = 3, GW = 3, CW = 6;
  localparam int NT = NS + NA;
  localparam int SW = $clog2(NT + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] raw_in = '0;
  logic [NA-1:0] aux_in = '0;
  logic [NS*DW-1:0] dly_cfg = '0;
  logic [NS*GW-1:0] gate_cfg = '0;
  logic cnt_clr = 1'b0;
  logic [SW-1:0] cnt_sel = '0;
  logic [NS-1:0] shaped_out;
  logic [CW-1:0] cnt_value;

  always #2 clk = ~clk;

  trig_shaper_bank #(.N_SHAPED(NS), .N_COUNT(NA), .DLY_W(DW), .GATE_W(GW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .aux_in(aux_in), .dly_cfg(dly_cfg),
    .gate_cfg(gate_cfg), .cnt_clr(cnt_clr), .cnt_sel(cnt_sel),
    .shaped_out(shaped_out), .cnt_value(cnt_value));

  int tests = 0, fails = 0, t = 0;
  bit done = 0, chk_en = 1;
  logic [NS-1:0] hist [64];
  int exp_cnt [NT];
  bit prev_in [NT];

  // Raw sample of channel ch at edge k (zero before the first edge).
  function automatic bit xs(input int k, input int ch);
    if (k <= 0) return 1'b0;
    return hist[k % 64][ch];
  endfunction

  // Output after edge u is high when some delayed edge happened at one of the W edges before.
  function automatic logic [NS-1:0] exp_shaped(input int u);
    logic [NS-1:0] r = '0;
    for (int ch = 0; ch < NS; ch++) begin
      int d = int'(dly_cfg[ch*DW +: DW]);
      int w = int'(gate_cfg[ch*GW +: GW]);
      for (int j = 0; j < w; j++) begin
        int te = u - 1 - j;
        if (xs(te - d, ch) && !xs(te - d - 1, ch)) r[ch] = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic check_counts(input string tag);
    for (int s = 0; s < NT + 2; s++) begin
      int e = (s < NT) ? exp_cnt[s] : 0;
      cnt_sel = SW'(s);
      #0.05;
      tests++;
      if (int'(cnt_value) != e) begin
        fails++;
        $display("FAIL %s (R9 readback) sel=%0d actual=%0d expected=%0d", tag, s, cnt_value, e);
      end
    end
  endtask

  task automatic cyc(input logic [NS-1:0] r, input logic [NA-1:0] a, input logic c);
    logic [NT-1:0] all;
    raw_in = r; aux_in = a; cnt_clr = c;
    t++;
    hist[t % 64] = r;
    all = {a, r};
    for (int i = 0; i < NT; i++) begin
      if (c) exp_cnt[i] = 0;
      else if (all[i] && !prev_in[i]) exp_cnt[i] = (exp_cnt[i] + 1) % (1 << CW);
      prev_in[i] = all[i];
    end
    @(posedge clk);
    @(negedge clk);
    if (chk_en) begin
      logic [NS-1:0] e = exp_shaped(t);
      tests++;
      if (shaped_out !== e) begin
        fails++;
        $display("FAIL R2 R3 R4 R5 R10 shaped t=%0d actual=%b expected=%b", t, shaped_out, e);
      end
    end
  endtask

  task automatic rand_cfg();
    for (int ch = 0; ch < NS; ch++) begin
      dly_cfg[ch*DW +: DW]  = DW'($urandom);
      gate_cfg[ch*GW +: GW] = GW'($urandom);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all R) actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 64; k++) hist[k] = '0;
    for (int i = 0; i < NT; i++) begin exp_cnt[i] = 0; prev_in[i] = 0; end
    rand_cfg();
    // Directed corners: D=0/W=1, max D/max W, W=0, D=2/W=3 for restarts.
    dly_cfg[0*DW +: DW] = 3'd0; gate_cfg[0*GW +: GW] = 3'd1;
    dly_cfg[1*DW +: DW] = 3'd7; gate_cfg[1*GW +: GW] = 3'd7;
    dly_cfg[2*DW +: DW] = 3'd1; gate_cfg[2*GW +: GW] = 3'd0;
    dly_cfg[3*DW +: DW] = 3'd2; gate_cfg[3*GW +: GW] = 3'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tests++;
    if (shaped_out !== '0) begin
      fails++; $display("FAIL R1 reset shaped actual=%b expected=0", shaped_out);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check_counts("R1 reset");

    // Single pulse on all inputs, then quiet: latency D+1 and width W (R2, R3, R5).
    cyc('1, '1, 0);
    repeat (20) cyc('0, '0, 0);
    check_counts("R6 single");
    // Long high counts once (R6).
    repeat (12) cyc('1, '1, 0);
    repeat (20) cyc('0, '0, 0);
    check_counts("R6 long");
    // Restart during gate on ch3 and others (R4).
    for (int k = 0; k < 6; k++) begin cyc('1, '0, 0); cyc('0, '0, 0); end
    repeat (20) cyc('0, '0, 0);
    // Edge sampled with clear is lost (R8).
    cyc('1, '1, 1);
    check_counts("R8 clear");
    cyc('0, '0, 0);
    check_counts("R8 after");
    // Wrap on aux[0] and raw[0] (R7).
    for (int k = 0; k < 70; k++) begin cyc(8'h01, 4'h1, 0); cyc('0, '0, 0); end
    repeat (10) cyc('0, '0, 0);
    check_counts("R7 wrap");

    // Random traffic, two configuration sets.
    for (int phase = 0; phase < 2; phase++) begin
      if (phase == 1) begin
        rand_cfg();
        chk_en = 0;
        repeat (20) cyc('0, '0, 0);
        chk_en = 1;
      end
      for (int n = 0; n < 3000; n++) begin
        logic [NS-1:0] r;
        logic [NA-1:0] a;
        for (int b = 0; b < NS; b++) r[b] = ($urandom % 4) == 0;
        for (int b = 0; b < NA; b++) a[b] = ($urandom % 3) == 0;
        cyc(r, a, ($urandom % 97) == 0);
        if (n % 16 == 15) check_counts("R6 R7 R8 random");
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule